// File: doc/BRIEF.md
# Interrupt Context Save and Restore Sequencer

This block sits next to a processor's main instruction sequencer. It acts only at instruction boundaries. When the main sequencer signals that an instruction has finished executing, the block makes one of three choices:

- It takes an interrupt, if a request is pending, software has enabled interrupts, and the block is not already masked.
- It starts a restore, if the finished instruction was the return-from-interrupt opcode.
- It does nothing, and the next fetch goes ahead.

When it takes an interrupt, the block holds the main sequencer. It then writes three words onto a stack in main memory that grows downward, using a shared valid/ready memory port:

- the return address from PC,
- the status flags,
- the general register.

After the third write it hands PC the fixed service-routine address. On a return it reads the three words back in reverse order and hands all three to the main sequencer in a single load pulse, so that fetch resumes at the restored PC.

The memory request channel follows valid/ready rules. Once `mem_valid_o` is high, it stays high with address, write flag and write data unchanged until a cycle in which `mem_ready_i` is also high; that cycle is the transfer. A read is answered by exactly one cycle of `mem_rvalid_i`, which must come at least one cycle after the read transfer. Only one read is ever outstanding, and the block accepts the response in whatever cycle it arrives.

Top module: `irq_ctx_seq`

## Requirements
- R1: After reset, `hold_o`, `mem_valid_o`, `pc_load_o`, `regs_load_o` and `masked_o` are low and `sp_o` equals `SP_INIT` (default 0x0200).
- R2: An interrupt request never causes activity unless `boundary_i` is high: without a boundary, `hold_o` and `mem_valid_o` stay low.
- R3: Interrupt entry performs three memory writes. Each write is sent to SP-1, and then SP steps down by one. The words written are, in order:
  - PC, zero-extended to the data width;
  - the status flags, zero-extended;
  - the general register.

  After entry, `sp_o` is 3 below its starting value.
- R4: After the third write, there is a single cycle in which `pc_load_o` is high, `pc_next_o` equals `ISR_ADDR` (default 0x100) and `regs_load_o` is low. `hold_o` is low in the following cycle.
- R5: Entry sets `masked_o`. While it is set, a boundary with any opcode other than the return opcode causes no entry, and the request stays pending. That request is taken at the first non-return boundary after the restore completes.
- R6: While `gie_i` is low, no entry occurs. A request seen in that time stays pending until `gie_i` is high at a boundary.
- R7: A boundary whose `opcode_i` equals `RTI_OPCODE` (default 4'hE) starts a restore of three reads. Each read is sent to SP, and then SP steps up by one. The words read are, in order, the general register, the status flags and PC; `sp_o` ends 3 above its starting value.
- R8: The restore ends with a single cycle in which both `pc_load_o` and `regs_load_o` are high. In that cycle:
  - `pc_next_o` carries the last word read;
  - `sr_next_o` carries the low `SR_W` bits of the second word;
  - `gpr_next_o` carries the first word.

  `masked_o` is low afterwards.
- R9: While `mem_valid_o` is high and `mem_ready_i` is low, the next cycle keeps `mem_valid_o` high and keeps `mem_addr_o`, `mem_we_o` and `mem_wdata_o` unchanged.
- R10: When a request is pending and the boundary carries the return opcode, the restore runs and no entry write is made at that boundary.
- R11: `hold_o` is high in the boundary cycle that starts a sequence, and it stays high up to and including the load-pulse cycle.
- R12: A request that is high for a single cycle between boundaries is remembered and taken at the next eligible boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 1 | Interrupt request; a pulse of a single cycle is latched |
| gie_i | input | 1 | Global interrupt enable from software |
| boundary_i | input | 1 | End of execute for the current instruction |
| opcode_i | input | OPC_W | Opcode of the instruction that just finished |
| pc_i | input | AW | Return address, meaning the already incremented PC |
| sr_i | input | SR_W | Status flags to save |
| gpr_i | input | DW | General register to save |
| hold_o | output | 1 | Main sequencer must not fetch while this is high |
| pc_load_o | output | 1 | Single-cycle pulse: load `pc_next_o` into PC |
| pc_next_o | output | AW | Service-routine address or restored PC |
| regs_load_o | output | 1 | Single-cycle pulse: load the restored flags and general register |
| sr_next_o | output | SR_W | Restored status flags |
| gpr_next_o | output | DW | Restored general register |
| masked_o | output | 1 | Automatic interrupt mask, set while a service routine runs |
| sp_o | output | AW | Stack pointer |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory request ready |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Request address |
| mem_wdata_o | output | DW | Write data |
| mem_rvalid_i | input | 1 | Read data valid, a single cycle per read |
| mem_rdata_i | input | DW | Read data |

## Verification
Two situations are hard to reach from the ports:

- A request arriving while the block is masked. The bench enters a service routine, pulses the request, and presents a plain boundary, which must be refused. It then returns from the routine and presents another plain boundary, which must start the deferred entry.
- A restore that returns words different from those pushed. The bench's memory model has its stack words overwritten between entry and return, so the restored values can only come from the reads and not from any copy held in the block.

Every entry and restore in the vector table runs against a different stall pattern on `mem_ready_i`, so that the hold-stable rule of R9 is exercised in the middle of both pushes and pops.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_POP_REQ,
    ST_POP_WAIT,
    ST_FIN_ENTRY,
    ST_FIN_EXIT
  } seq_state_t;

  // Number of saved words and their slot positions (push order).
  localparam int CTX_WORDS = 3;
  localparam int SLOT_PC   = 0;
  localparam int SLOT_SR   = 1;
  localparam int SLOT_GPR  = 2;
endpackage

// File: rtl/ctx_boundary_decider.sv
module ctx_boundary_decider #(
  parameter int OPC_W = 4,
  parameter logic [OPC_W-1:0] RTI_OPCODE = 4'hE
) (
  input  logic             idle,
  input  logic             boundary,
  input  logic [OPC_W-1:0] opcode,
  input  logic             irq_pending,
  input  logic             gie,
  input  logic             masked,
  output logic             take_irq,
  output logic             take_rti
);
  logic is_rti;

  always_comb begin
    is_rti   = (opcode == RTI_OPCODE);
    // Return has priority over a pending request at the same boundary.
    take_rti = idle && boundary && is_rti;
    take_irq = idle && boundary && !is_rti && irq_pending && gie && !masked;
  end
endmodule

// File: rtl/ctx_stack_ptr.sv
module ctx_stack_ptr #(
  parameter int AW = 16,
  parameter logic [AW-1:0] SP_INIT = 16'h0200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec,
  input  logic          inc,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] sp_below
);
  always_ff @(posedge clk) begin
    if (!rst_n)   sp <= SP_INIT;
    else if (dec) sp <= sp - AW'(1);
    else if (inc) sp <= sp + AW'(1);
  end

  assign sp_below = sp - AW'(1);
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
  import irq_ctx_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int SR_W = 8,
  parameter int OPC_W = 4,
  parameter logic [OPC_W-1:0] RTI_OPCODE = 4'hE,
  parameter logic [AW-1:0] ISR_ADDR = 16'h0100,
  parameter logic [AW-1:0] SP_INIT = 16'h0200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_i,
  input  logic             gie_i,
  input  logic             boundary_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [SR_W-1:0]  sr_i,
  input  logic [DW-1:0]    gpr_i,
  output logic             hold_o,
  output logic             pc_load_o,
  output logic [AW-1:0]    pc_next_o,
  output logic             regs_load_o,
  output logic [SR_W-1:0]  sr_next_o,
  output logic [DW-1:0]    gpr_next_o,
  output logic             masked_o,
  output logic [AW-1:0]    sp_o,
  output logic             mem_valid_o,
  input  logic             mem_ready_i,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_rvalid_i,
  input  logic [DW-1:0]    mem_rdata_i
);
  localparam int SLOT_W = $clog2(CTX_WORDS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CTX_WORDS - 1);

  seq_state_t        state_q, state_d;
  logic [SLOT_W-1:0] slot_q;
  logic [DW-1:0]     ctx_q [CTX_WORDS];
  logic [DW-1:0]     ctx_in [CTX_WORDS];
  logic              pend_q, masked_q;
  logic              take_irq, take_rti, idle;
  logic              sp_dec, sp_inc, xfer;
  logic [AW-1:0]     sp, sp_below;
  logic [SLOT_W-1:0] pop_slot;

  assign idle = (state_q == ST_IDLE);

  ctx_boundary_decider #(.OPC_W(OPC_W), .RTI_OPCODE(RTI_OPCODE)) u_decide (
    .idle        (idle),
    .boundary    (boundary_i),
    .opcode      (opcode_i),
    .irq_pending (pend_q | irq_i),
    .gie         (gie_i),
    .masked      (masked_q),
    .take_irq    (take_irq),
    .take_rti    (take_rti)
  );

  ctx_stack_ptr #(.AW(AW), .SP_INIT(SP_INIT)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec      (sp_dec),
    .inc      (sp_inc),
    .sp       (sp),
    .sp_below (sp_below)
  );

  // Words captured at the boundary, in push order.
  always_comb begin
    ctx_in[SLOT_PC]  = DW'(pc_i);
    ctx_in[SLOT_SR]  = DW'(sr_i);
    ctx_in[SLOT_GPR] = gpr_i;
  end

  // Pops arrive in reverse order: the first read fills the last slot.
  assign pop_slot = LAST_SLOT - slot_q;
  assign xfer     = mem_valid_o && mem_ready_i;
  assign sp_dec   = (state_q == ST_PUSH) && xfer;
  assign sp_inc   = (state_q == ST_POP_REQ) && xfer;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (take_irq) state_d = ST_PUSH;
                    else if (take_rti) state_d = ST_POP_REQ;
      ST_PUSH:      if (xfer && slot_q == LAST_SLOT) state_d = ST_FIN_ENTRY;
      ST_POP_REQ:   if (xfer) state_d = ST_POP_WAIT;
      ST_POP_WAIT:  if (mem_rvalid_i)
                      state_d = (slot_q == LAST_SLOT) ? ST_FIN_EXIT : ST_POP_REQ;
      ST_FIN_ENTRY: state_d = ST_IDLE;
      ST_FIN_EXIT:  state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      slot_q   <= '0;
      pend_q   <= 1'b0;
      masked_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take_irq)     pend_q <= 1'b0;
      else if (irq_i)   pend_q <= 1'b1;
      if (take_irq)                    masked_q <= 1'b1;
      else if (state_q == ST_FIN_EXIT) masked_q <= 1'b0;
      if (idle) slot_q <= '0;
      else if (sp_dec || (state_q == ST_POP_WAIT && mem_rvalid_i))
        slot_q <= slot_q + SLOT_W'(1);
    end
  end

  for (genvar g = 0; g < CTX_WORDS; g++) begin : g_ctx
    always_ff @(posedge clk) begin
      if (!rst_n) ctx_q[g] <= '0;
      else if (take_irq) ctx_q[g] <= ctx_in[g];
      else if (state_q == ST_POP_WAIT && mem_rvalid_i && pop_slot == SLOT_W'(g))
        ctx_q[g] <= mem_rdata_i;
    end
  end

  always_comb begin
    mem_valid_o = (state_q == ST_PUSH) || (state_q == ST_POP_REQ);
    mem_we_o    = (state_q == ST_PUSH);
    mem_addr_o  = (state_q == ST_PUSH) ? sp_below : sp;
    mem_wdata_o = (state_q == ST_PUSH) ? ctx_q[slot_q] : '0;
    pc_load_o   = (state_q == ST_FIN_ENTRY) || (state_q == ST_FIN_EXIT);
    regs_load_o = (state_q == ST_FIN_EXIT);
    pc_next_o   = (state_q == ST_FIN_EXIT) ? ctx_q[SLOT_PC][AW-1:0] : ISR_ADDR;
    sr_next_o   = ctx_q[SLOT_SR][SR_W-1:0];
    gpr_next_o  = ctx_q[SLOT_GPR];
    hold_o      = !idle || take_irq || take_rti;
    masked_o    = masked_q;
    sp_o        = sp;
  end
endmodule

// File: rtl/irq_ctx_seq_chk.sv
module irq_ctx_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int OPC_W = 4,
  parameter logic [OPC_W-1:0] RTI_OPCODE = 4'hE
) (
  input logic             clk,
  input logic             rst_n,
  input logic             boundary_i,
  input logic [OPC_W-1:0] opcode_i,
  input logic             hold_o,
  input logic             pc_load_o,
  input logic             regs_load_o,
  input logic             masked_o,
  input logic [AW-1:0]    sp_o,
  input logic             mem_valid_o,
  input logic             mem_ready_i,
  input logic             mem_we_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic [DW-1:0]    mem_wdata_o
);
  // R9
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)
                                  && $stable(mem_we_o) && $stable(mem_wdata_o));

  // R3
  push_sp_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && mem_ready_i && mem_we_o |=> sp_o == $past(sp_o) - AW'(1));

  // R7
  pop_sp_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && mem_ready_i && !mem_we_o |=> sp_o == $past(sp_o) + AW'(1));

  // R4
  release_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |=> !hold_o && !pc_load_o);

  // R8
  regs_with_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regs_load_o |-> pc_load_o && hold_o);

  // R2
  quiet_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_o |-> !mem_valid_o && !pc_load_o);

  // R5
  masked_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    masked_o && !$past(hold_o) && boundary_i && opcode_i != RTI_OPCODE |-> !hold_o);
endmodule

bind irq_ctx_seq irq_ctx_seq_chk #(
  .AW(AW), .DW(DW), .OPC_W(OPC_W), .RTI_OPCODE(RTI_OPCODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .opcode_i(opcode_i),
  .hold_o(hold_o), .pc_load_o(pc_load_o), .regs_load_o(regs_load_o),
  .masked_o(masked_o), .sp_o(sp_o), .mem_valid_o(mem_valid_o),
  .mem_ready_i(mem_ready_i), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o)
);

// File: tb/irq_ctx_seq_tb.sv
`timescale 1ns/1ps
module irq_ctx_seq_tb;
  localparam logic [15:0] ISR = 16'h0100;
  localparam logic [15:0] SP0 = 16'h0200;
  localparam logic [3:0]  RTI = 4'hE;
  // {pc, sr, gpr, new_pc, new_sr, new_gpr, stall pattern}
  localparam int NV = 4;
  localparam logic [91:0] VEC [NV] = '{
    {16'h1234, 8'h5A, 16'hBEEF, 16'h2222, 16'h00C3, 16'h7777, 4'b0000},
    {16'h0042, 8'h81, 16'h0001, 16'h3F00, 16'hA5C3, 16'hFFFF, 4'b0101},
    {16'hFFFE, 8'h00, 16'h8000, 16'h0010, 16'h0011, 16'h0000, 4'b0011},
    {16'h0800, 8'hFF, 16'h1357, 16'h4444, 16'hFF80, 16'h2468, 4'b0110}
  };

  logic clk = 0, rst_n = 0;
  logic irq_i = 0, gie_i = 1, boundary_i = 0;
  logic [3:0] opcode_i = 0;
  logic [15:0] pc_i = 0, gpr_i = 0;
  logic [7:0] sr_i = 0;
  logic hold_o, pc_load_o, regs_load_o, masked_o, mem_valid_o, mem_we_o;
  logic [15:0] pc_next_o, gpr_next_o, sp_o, mem_addr_o, mem_wdata_o;
  logic [7:0] sr_next_o;
  logic mem_ready_i = 1, mem_rvalid_i = 0;
  logic [15:0] mem_rdata_i = 0;

  always #4 clk = ~clk;

  irq_ctx_seq u_dut (.*);

  int checks = 0, failures = 0;
  logic [15:0] mem [256];
  logic [15:0] wr_a [16], wr_d [16], rd_a [16];
  int wr_cnt = 0, rd_cnt = 0, ld_cnt = 0, cyc = 0;
  logic [15:0] ld_pc, ld_gpr;
  logic [7:0] ld_sr;
  logic ld_regs;
  logic [3:0] stall_pat = 0;
  logic acc_rd = 0;
  logic [15:0] acc_a = 0;
  logic p_stall = 0;
  logic [15:0] p_addr, p_data;
  logic p_we;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory model: transfers observed at the edge, responses driven at negedge.
  always @(posedge clk) begin
    acc_rd = 0;
    if (rst_n) begin
      if (p_stall) chk(mem_valid_o && mem_addr_o == p_addr && mem_we_o == p_we
                       && mem_wdata_o == p_data, "R9", "held request",
                       {mem_addr_o, mem_wdata_o}, {p_addr, p_data});
      p_stall = mem_valid_o && !mem_ready_i;
      p_addr = mem_addr_o; p_data = mem_wdata_o; p_we = mem_we_o;
      if (mem_valid_o && mem_ready_i) begin
        if (mem_we_o) begin
          mem[mem_addr_o[7:0]] = mem_wdata_o;
          wr_a[wr_cnt % 16] = mem_addr_o; wr_d[wr_cnt % 16] = mem_wdata_o; wr_cnt++;
        end else begin
          acc_rd = 1; acc_a = mem_addr_o;
          rd_a[rd_cnt % 16] = mem_addr_o; rd_cnt++;
        end
      end
      if (pc_load_o) begin
        ld_pc = pc_next_o; ld_sr = sr_next_o; ld_gpr = gpr_next_o;
        ld_regs = regs_load_o; ld_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    mem_rvalid_i <= acc_rd;
    mem_rdata_i  <= acc_rd ? mem[acc_a[7:0]] : 16'h0;
    mem_ready_i  <= !stall_pat[cyc % 4];
    cyc++;
  end

  task automatic pulse_irq();
    @(negedge clk); irq_i = 1;
    @(negedge clk); irq_i = 0;
  endtask

  // Presents one boundary; returns hold_o as seen in that cycle.
  task automatic boundary(input logic [3:0] op, output logic held);
    @(negedge clk); boundary_i = 1; opcode_i = op;
    #1 held = hold_o;
    @(negedge clk); boundary_i = 0; opcode_i = 0;
  endtask

  task automatic wait_load(input int n0);
    while (ld_cnt == n0) @(negedge clk);
  endtask

  task automatic do_entry(input string req);
    logic held;
    int w0, n0;
    logic [15:0] s0;
    w0 = wr_cnt; n0 = ld_cnt; s0 = sp_o;
    boundary(4'h0, held);
    chk(held, "R11", "hold at taking boundary", held, 1);
    wait_load(n0);
    chk(wr_cnt - w0 == 3, req, "entry write count", wr_cnt - w0, 3);
    chk(ld_pc == ISR && !ld_regs, "R4", "entry load", {ld_regs, ld_pc}, {1'b0, ISR});
    chk(hold_o == 0, "R4", "hold released", hold_o, 0);
    chk(masked_o, "R5", "masked after entry", masked_o, 1);
    chk(sp_o == s0 - 16'd3, "R3", "sp after push", sp_o, s0 - 16'd3);
  endtask

  task automatic do_restore(input string req);
    logic held;
    int r0, n0;
    logic [15:0] s0;
    r0 = rd_cnt; n0 = ld_cnt; s0 = sp_o;
    boundary(RTI, held);
    chk(held, "R11", "hold at return boundary", held, 1);
    wait_load(n0);
    chk(rd_cnt - r0 == 3, req, "restore read count", rd_cnt - r0, 3);
    chk(ld_regs, "R8", "regs load with pc", ld_regs, 1);
    chk(!masked_o, "R8", "unmasked after restore", masked_o, 0);
    chk(sp_o == s0 + 16'd3, "R7", "sp after pop", sp_o, s0 + 16'd3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic held;
    int w0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!hold_o && !mem_valid_o && !pc_load_o && !regs_load_o && !masked_o,
        "R1", "reset outputs", {hold_o, mem_valid_o, pc_load_o, regs_load_o, masked_o}, 0);
    chk(sp_o == SP0, "R1", "reset sp", sp_o, SP0);

    for (int v = 0; v < NV; v++) begin
      logic [91:0] e;
      int w1, r1;
      e = VEC[v];
      pc_i = e[91:76]; sr_i = e[75:68]; gpr_i = e[67:52]; stall_pat = e[3:0];
      w1 = wr_cnt;
      pulse_irq();
      repeat (3) @(negedge clk);
      // R2 and R12: no activity without a boundary, request remembered
      chk(!hold_o && wr_cnt == w1, "R2", "no entry without boundary", hold_o, 0);
      do_entry("R12");
      chk(wr_a[w1 % 16] == SP0 - 1 && wr_a[(w1 + 1) % 16] == SP0 - 2 &&
          wr_a[(w1 + 2) % 16] == SP0 - 3, "R3", "push addresses",
          wr_a[(w1 + 2) % 16], SP0 - 3);
      chk(wr_d[w1 % 16] == e[91:76], "R3", "push PC", wr_d[w1 % 16], e[91:76]);
      chk(wr_d[(w1 + 1) % 16] == {8'h0, e[75:68]}, "R3", "push SR",
          wr_d[(w1 + 1) % 16], {8'h0, e[75:68]});
      chk(wr_d[(w1 + 2) % 16] == e[67:52], "R3", "push GPR",
          wr_d[(w1 + 2) % 16], e[67:52]);
      // Overwrite stacked words so the restore must read memory.
      mem[8'hFF] = e[51:36]; mem[8'hFE] = e[35:20]; mem[8'hFD] = e[19:4];
      r1 = rd_cnt;
      do_restore("R7");
      chk(rd_a[r1 % 16] == SP0 - 3 && rd_a[(r1 + 1) % 16] == SP0 - 2 &&
          rd_a[(r1 + 2) % 16] == SP0 - 1, "R7", "pop addresses",
          rd_a[r1 % 16], SP0 - 3);
      chk(ld_pc == e[51:36], "R8", "restored PC", ld_pc, e[51:36]);
      chk(ld_sr == e[27:20], "R8", "restored SR", ld_sr, e[27:20]);
      chk(ld_gpr == e[19:4], "R8", "restored GPR", ld_gpr, e[19:4]);
    end
    stall_pat = 4'b0000;

    // R6: global enable low blocks entry, request stays pending
    gie_i = 0;
    pulse_irq();
    boundary(4'h0, held);
    repeat (2) @(negedge clk);
    chk(!held && !hold_o && !masked_o, "R6", "gie low blocks", held, 0);
    gie_i = 1;
    do_entry("R6");

    // R5: masked request deferred until after restore
    pulse_irq();
    w0 = wr_cnt;
    boundary(4'h3, held);
    repeat (2) @(negedge clk);
    chk(!held && wr_cnt == w0, "R5", "masked boundary refused", held, 0);
    do_restore("R5");
    do_entry("R5");
    do_restore("R5");

    // R10: return opcode wins over a pending request
    pulse_irq();
    w0 = wr_cnt;
    do_restore("R10");
    chk(wr_cnt == w0, "R10", "no push at return boundary", wr_cnt - w0, 0);
    do_entry("R10");
    chk(sp_o == SP0, "R10", "sp after deferred entry", sp_o, SP0);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule